// File: doc/BRIEF.md
# SPI Clock Stall Watchdog

This block watches the synchronised serial clock and active-low chip-select of an SPI target while a frame is open. Whenever chip-select is low and the serial clock stops changing for longer than a selectable time, it emits a one-cycle reset pulse for the SPI receive logic and latches a sticky timeout flag. Separately, if chip-select is released after the frame has started but before the receive logic has reported a complete command, it latches a sticky chip-select abort flag.

The stall time is chosen by a 4-bit code from a fixed non-linear table, measured in 100 us ticks produced by an internal prescaler (`TICK_DIV` system clocks per tick). Code 0 turns the check off. The register that drives the code is expected to come out of reset holding 0xA (30 ms). Shifting and decoding of SPI data are done elsewhere. That logic supplies the bit-count-complete pulse and consumes the reset pulse.

Top module: `spi_clk_watchdog`

## Requirements
- R1: After reset, `spi_reset`, `flag_timeout` and `flag_cs_abort` are all 0.
- R2: The stall limit in 100 us ticks is, by code: 1=5, 2=10, 3=20, 4=30, 5=40, 6=50, 7=100, 8=150, 9=200, 10=300, 11=400, 12=500, 13=850, 14=1000, 15=2000. Take the last rising clock edge at which the stall timer was reloaded (chip-select high, or `sclk_sync` differing from its previous sample) and call it edge 0. If `csn_sync` then stays low with no further change of `sclk_sync`, `spi_reset` is high during the cycle after edge limit×`TICK_DIV`.
- R3: Any change of `sclk_sync` while `csn_sync` is low restarts the stall timer. Traffic whose gaps are shorter than the limit never produces `spi_reset`.
- R4: With code 0 the check is off: no `spi_reset` pulse and no timeout flag, however long the clock stalls.
- R5: `spi_reset` is a single-cycle pulse, issued once per stall. No further pulse follows until a new `sclk_sync` change or a chip-select release re-arms the timer.
- R6: While `csn_sync` is high the timer is held cleared and no `spi_reset` is produced.
- R7: `flag_timeout` rises with the `spi_reset` pulse and stays set until it is cleared.
- R8: A low-to-high change of `csn_sync` sets `flag_cs_abort` on that clock edge if at least one `sclk_sync` change was seen in the frame and no `cmd_bits_done` pulse has arrived in it (a pulse in the same cycle counts). A timeout also restarts the command tracking.
- R9: `flags_clear` high for one cycle clears both flags on the next edge. A set event in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_sync | input | 1 | Serial clock, already synchronised to `clk` |
| csn_sync | input | 1 | Active-low chip-select, already synchronised |
| tmo_code | input | 4 | Stall time selector, 0 disables |
| cmd_bits_done | input | 1 | Pulse from the receiver when a full command has been shifted in |
| flags_clear | input | 1 | Clears both sticky flags |
| spi_reset | output | 1 | One-cycle reset pulse for the SPI receive logic |
| flag_timeout | output | 1 | Sticky clock-stall flag |
| flag_cs_abort | output | 1 | Sticky early chip-select release flag |

## Verification
The hardest case to reach is the exact cycle on which a stall fires for every table entry. This needs a long, quiet stretch with chip-select held low after one precisely placed clock change. The bench shortens the prescaler to two cycles per tick and walks through all fifteen non-zero codes. For each code it toggles the clock once and counts cycles to the pulse, comparing against a limit that it computes itself from microsecond values. Random bursts of clock changes, with gaps drawn just under the limit, show that the timer re-arms on every change.

// File: rtl/spi_wd_pkg.sv
package spi_wd_pkg;
  localparam int WD_LIMIT_W = 12;
  typedef logic [WD_LIMIT_W-1:0] wd_limit_t;

  // Stall limit, in 100 us ticks, for each selector code (0 = off)
  function automatic wd_limit_t wd_ticks_for_code(input logic [3:0] code);
    case (code)
      4'h1: return wd_limit_t'(5);
      4'h2: return wd_limit_t'(10);
      4'h3: return wd_limit_t'(20);
      4'h4: return wd_limit_t'(30);
      4'h5: return wd_limit_t'(40);
      4'h6: return wd_limit_t'(50);
      4'h7: return wd_limit_t'(100);
      4'h8: return wd_limit_t'(150);
      4'h9: return wd_limit_t'(200);
      4'hA: return wd_limit_t'(300);
      4'hB: return wd_limit_t'(400);
      4'hC: return wd_limit_t'(500);
      4'hD: return wd_limit_t'(850);
      4'hE: return wd_limit_t'(1000);
      4'hF: return wd_limit_t'(2000);
      default: return wd_limit_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/wd_edge_mon.sv
module wd_edge_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_sync,
  input  logic csn_sync,
  output logic sclk_edge,
  output logic cs_rise
);
  logic sclk_q;
  logic csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_sync;
      csn_q  <= csn_sync;
    end
  end

  assign sclk_edge = sclk_sync ^ sclk_q;
  assign cs_rise   = csn_sync & ~csn_q;
endmodule

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
  parameter int TICK_DIV = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wd_stall_timer.sv
module wd_stall_timer
  import spi_wd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reload,
  input  logic      tick,
  input  wd_limit_t limit,
  output logic      hit
);
  wd_limit_t cnt;
  logic      armed;
  logic [WD_LIMIT_W:0] next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign hit = armed && tick && !reload && (limit != '0)
               && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (reload) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (hit) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed && tick && (limit != '0)) begin
      cnt   <= next_cnt[WD_LIMIT_W-1:0];
    end
  end
endmodule

// File: rtl/spi_clk_watchdog.sv
module spi_clk_watchdog
  import spi_wd_pkg::*;
#(
  parameter int TICK_DIV = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_sync,
  input  logic       csn_sync,
  input  logic [3:0] tmo_code,
  input  logic       cmd_bits_done,
  input  logic       flags_clear,
  output logic       spi_reset,
  output logic       flag_timeout,
  output logic       flag_cs_abort
);
  logic sclk_edge;
  logic cs_rise;
  logic reload;
  logic tick;
  logic tmo_hit;
  logic cs_err_hit;
  logic seen_edge;
  logic cmd_done;
  wd_limit_t limit;

  wd_edge_mon u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_sync(sclk_sync), .csn_sync(csn_sync),
    .sclk_edge(sclk_edge), .cs_rise(cs_rise)
  );

  assign reload = csn_sync | sclk_edge;
  assign limit  = wd_ticks_for_code(tmo_code);

  wd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(reload), .tick(tick)
  );

  wd_stall_timer u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload), .tick(tick),
    .limit(limit), .hit(tmo_hit)
  );

  // Command progress within the current frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_edge <= 1'b0;
      cmd_done  <= 1'b0;
    end else if (csn_sync || tmo_hit) begin
      seen_edge <= 1'b0;
      cmd_done  <= 1'b0;
    end else begin
      if (sclk_edge)     seen_edge <= 1'b1;
      if (cmd_bits_done) cmd_done  <= 1'b1;
    end
  end

  assign cs_err_hit = cs_rise && seen_edge && !cmd_done && !cmd_bits_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_reset     <= 1'b0;
      flag_timeout  <= 1'b0;
      flag_cs_abort <= 1'b0;
    end else begin
      spi_reset <= tmo_hit;
      if (tmo_hit)          flag_timeout <= 1'b1;
      else if (flags_clear) flag_timeout <= 1'b0;
      if (cs_err_hit)       flag_cs_abort <= 1'b1;
      else if (flags_clear) flag_cs_abort <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_clk_watchdog_chk.sv
module spi_clk_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_sync,
  input logic [3:0] tmo_code,
  input logic       flags_clear,
  input logic       sclk_edge,
  input logic       tmo_hit,
  input logic       cs_err_hit,
  input logic       spi_reset,
  input logic       flag_timeout,
  input logic       flag_cs_abort
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    spi_reset |=> !spi_reset);
  a_r3_edge_blocks_fire: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_edge |=> !spi_reset);
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_code == 4'd0) |=> !spi_reset);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    csn_sync |=> !spi_reset);
  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    spi_reset |-> flag_timeout);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_timeout && !flags_clear) |=> flag_timeout);
  a_r8_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cs_err_hit |=> flag_cs_abort);
  a_r9_clear_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_clear && !tmo_hit) |=> !flag_timeout);
  a_r9_clear_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_clear && !cs_err_hit) |=> !flag_cs_abort);
endmodule

bind spi_clk_watchdog spi_clk_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn_sync(csn_sync), .tmo_code(tmo_code),
  .flags_clear(flags_clear), .sclk_edge(sclk_edge), .tmo_hit(tmo_hit),
  .cs_err_hit(cs_err_hit), .spi_reset(spi_reset),
  .flag_timeout(flag_timeout), .flag_cs_abort(flag_cs_abort)
);

// File: tb/sim_spi_clk_watchdog.sv
module sim_spi_clk_watchdog;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_sync = 1'b0;
  logic csn_sync = 1'b1;
  logic [3:0] tmo_code = 4'hA;
  logic cmd_bits_done = 1'b0;
  logic flags_clear = 1'b0;
  logic spi_reset, flag_timeout, flag_cs_abort;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_clk_watchdog #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_sync(sclk_sync), .csn_sync(csn_sync),
    .tmo_code(tmo_code), .cmd_bits_done(cmd_bits_done),
    .flags_clear(flags_clear), .spi_reset(spi_reset),
    .flag_timeout(flag_timeout), .flag_cs_abort(flag_cs_abort)
  );

  // Stall time in microseconds per code, turned into system cycles
  function automatic int exp_cycles(input int code);
    int us;
    case (code)
      1: us = 500;     2: us = 1000;    3: us = 2000;    4: us = 3000;
      5: us = 4000;    6: us = 5000;    7: us = 10000;   8: us = 15000;
      9: us = 20000;   10: us = 30000;  11: us = 40000;  12: us = 50000;
      13: us = 85000;  14: us = 100000; 15: us = 200000;
      default: us = 0;
    endcase
    return (us / 100) * DIV;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); flags_clear = 1'b1;
    @(negedge clk); flags_clear = 1'b0;
  endtask

  task automatic open_frame();
    @(negedge clk); csn_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk); csn_sync = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Toggle the clock once, then count cycles until the reset pulse
  task automatic measure(input int code);
    int first = 0;
    int highs = 0;
    int exp = exp_cycles(code) + 1;
    clear_flags();
    open_frame();
    tmo_code = 4'(code);
    sclk_sync = ~sclk_sync;
    for (int n = 1; n <= exp + 6; n++) begin
      @(negedge clk);
      if (spi_reset) begin
        highs++;
        if (first == 0) first = n;
      end
    end
    chk(first == exp, $sformatf("R2 code %0d pulse cycle", code), first, exp);
    chk(highs == 1, "R5 single pulse", highs, 1);
    chk(flag_timeout == 1'b1, "R7 flag set", int'(flag_timeout), 1);
    close_frame();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_reset == 0, "R1 spi_reset", int'(spi_reset), 0);
    chk(flag_timeout == 0, "R1 flag_timeout", int'(flag_timeout), 0);
    chk(flag_cs_abort == 0, "R1 flag_cs_abort", int'(flag_cs_abort), 0);

    // R2/R5/R7 every table entry
    for (int c = 1; c < 16; c++) measure(c);

    // R7 flag stays until cleared, R9 clear
    chk(flag_timeout == 1'b1, "R7 sticky", int'(flag_timeout), 1);
    clear_flags();
    @(negedge clk);
    chk(flag_timeout == 1'b0, "R9 clear timeout", int'(flag_timeout), 0);

    // R4 disabled code
    open_frame();
    tmo_code = 4'd0;
    sclk_sync = ~sclk_sync;
    pulses = 0;
    repeat (4500) begin @(negedge clk); if (spi_reset) pulses++; end
    chk(pulses == 0, "R4 no pulse when off", pulses, 0);
    chk(flag_timeout == 1'b0, "R4 no flag when off", int'(flag_timeout), 0);
    close_frame();

    // R6 chip-select high holds the timer
    tmo_code = 4'd1;
    pulses = 0;
    repeat (300) begin @(negedge clk); if (spi_reset) pulses++; end
    chk(pulses == 0, "R6 idle no pulse", pulses, 0);

    // R3 random traffic with gaps below the limit
    for (int t = 0; t < 6; t++) begin
      int code = 1 + int'($urandom % 6);
      int lim = exp_cycles(code);
      open_frame();
      tmo_code = 4'(code);
      pulses = 0;
      for (int k = 0; k < 25; k++) begin
        int gap = 1 + int'($urandom % (lim - 2));
        sclk_sync = ~sclk_sync;
        repeat (gap) begin @(negedge clk); if (spi_reset) pulses++; end
      end
      chk(pulses == 0, "R3 traffic keeps timer alive", pulses, 0);
      chk(flag_timeout == 1'b0, "R3 no flag on traffic", int'(flag_timeout), 0);
      close_frame();
    end

    // R8 early release after clock activity
    tmo_code = 4'hA;
    open_frame();
    repeat (3) begin sclk_sync = ~sclk_sync; repeat (2) @(negedge clk); end
    csn_sync = 1'b1;
    @(negedge clk);
    chk(flag_cs_abort == 1'b1, "R8 abort flagged", int'(flag_cs_abort), 1);
    close_frame();
    clear_flags();
    @(negedge clk);
    chk(flag_cs_abort == 1'b0, "R9 clear abort", int'(flag_cs_abort), 0);

    // R8 completed command: no flag
    open_frame();
    repeat (3) begin sclk_sync = ~sclk_sync; repeat (2) @(negedge clk); end
    cmd_bits_done = 1'b1;
    @(negedge clk); cmd_bits_done = 1'b0;
    csn_sync = 1'b1;
    repeat (2) @(negedge clk);
    chk(flag_cs_abort == 1'b0, "R8 complete command no flag", int'(flag_cs_abort), 0);

    // R8 release without any clock change: no flag
    open_frame();
    csn_sync = 1'b1;
    repeat (2) @(negedge clk);
    chk(flag_cs_abort == 1'b0, "R8 empty frame no flag", int'(flag_cs_abort), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule